// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block brings a switchable logic domain up and down by driving its supply enable, two clock enables, domain reset, isolation clamp and the memory-controller flush handshake for the domain's client port. Every step happens in a fixed order, and a fixed settle interval separates consecutive steps. Power-up and power-down use different orders. The interlock between clamp, reset and flush keeps the domain isolated and its memory traffic drained whenever it is not fully powered.

Software starts a sequence with a single-cycle `up_req` or `down_req` pulse. The sequencer takes three status inputs: `rail_ready` from the rail control, `flush_ack` from the memory controller, and `secure_cfg_ok`, which reports a valid protected-memory setup. All pins are plain levels or single-cycle pulses. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. A request that the block cannot act on is dropped and is never queued. The settle interval is `CLK_MHZ * SETTLE_US` clock cycles. One shared down-counter times every settle interval and also the rail-ready timeout.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the domain is off: `rail_en`=0, `ref_clk_en`=0, `pwr_clk_en`=0, `dom_reset`=1, `iso_clamp`=1, `mc_flush_req`=1, `mc_flush_done`=0, `busy`=0, `error`=0, `dom_on`=0.
- R2: A power-up request, when the domain is off and `secure_cfg_ok`=1, runs these steps in order:
  1. Set `rail_en`=1.
  2. Wait for `rail_ready`, then set both clock enables to 1.
  3. Hold `dom_reset` asserted for one settle step.
  4. Release `iso_clamp` to 0.
  5. Release `dom_reset` to 0.
  6. Drop `mc_flush_req` and raise `mc_flush_done`.
  7. Drop `mc_flush_done`. The domain is then on.
- R3: A power-down request, when the domain is on, runs these steps in order:
  1. Set `mc_flush_req`=1.
  2. Wait for `flush_ack`, then one settle step, then set `iso_clamp`=1.
  3. Set `dom_reset`=1.
  4. Clear both clock enables.
  5. Clear `rail_en`. The domain is then off.
- R4: The steps are spaced by a fixed number of clock cycles, `CLK_MHZ*SETTLE_US` (S):
  - In power-up, the clamp release comes 2S cycles after the clocks are enabled. Every later output change comes S cycles after the one before it.
  - In power-down, every output change after the clamp engages comes S cycles after the one before it.
- R5: If `secure_cfg_ok`=0 when a power-up is requested from off, `error` rises one cycle later, no control output changes and `done` does not pulse.
- R6: If `rail_ready` stays low for `RAIL_TMO` cycles after `rail_en` rises, then in that cycle:
  - `rail_en` returns to 0 and `error` is set.
  - The clocks are never enabled.
  - The domain stays off and `done` does not pulse.
- R7: A request that arrives while `busy`=1 is ignored. The sequence in progress continues unchanged.
- R8: A power-up request while on, or a power-down request while off, pulses `done` in the next cycle and changes no control output.
- R9: `error` holds until `err_clear` is pulsed. While `error`=1, a power-up request is ignored (no `done`, no change) and a power-down request is accepted.
- R10: `mc_client_id` carries the domain's memory client number, `CLIENT_ID` (default 34).
- R11: The clock enables are high only while `rail_en`=1. `iso_clamp`=0 only while both clocks and the rail are enabled. `mc_flush_req` and `mc_flush_done` are never high together.
- R12: `busy` is high from the cycle after an accepted request until the sequence ends. `done` is a single-cycle pulse in the cycle the domain reaches its final on or off state, and `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Power-up request pulse |
| down_req | input | 1 | Power-down request pulse; wins over `up_req` in the same cycle |
| err_clear | input | 1 | Pulse to clear the error flag |
| secure_cfg_ok | input | 1 | Protected-memory configuration is valid |
| rail_ready | input | 1 | Supply rail reached its level |
| flush_ack | input | 1 | Memory controller finished flushing the client |
| rail_en | output | 1 | Supply rail enable |
| ref_clk_en | output | 1 | Reference clock enable |
| pwr_clk_en | output | 1 | Power clock enable |
| dom_reset | output | 1 | Domain reset, 1 = asserted |
| iso_clamp | output | 1 | Isolation clamp, 1 = engaged |
| mc_flush_req | output | 1 | Flush/block request to the memory controller |
| mc_flush_done | output | 1 | Flush-done release to the memory controller |
| mc_client_id | output | CID_W | Memory client number of the domain |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky error flag |
| dom_on | output | 1 | Domain is fully on |

## Verification
The bound assertions check the electrical interlocks in every cycle: clocks only with the rail, the clamp released only on a fully powered domain, reset released only after the clamp opens and asserted only after it closes, flush request and flush-done mutually exclusive, the sticky error and the one-cycle idle `done`. The bench scenarios show the behaviours that need a history of stimulus. These are the exact step order and cycle spacing of each sequence, the waits on `rail_ready` and `flush_ack`, the aborts on a bad security setup or a rail timeout, and dropped requests while busy or in error. A scoreboard catches each of these as a missing, extra or mistimed output change.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_ON,
    ST_RAIL,     // rail enabled, waiting for ready or timeout
    ST_CLK,      // clocks just enabled, settling
    ST_RST,      // reset asserted step, settling
    ST_CLAMP,    // clamp just released, settling
    ST_UNRST,    // reset just released, settling
    ST_FDONE,    // flush-done raised, settling
    ST_FACK,     // flush requested, waiting for acknowledge
    ST_FLUSH,    // flush acknowledged, settling
    ST_ISO,      // clamp just engaged, settling
    ST_RSTON,    // reset just asserted, settling
    ST_CLKOFF    // clocks just disabled, settling
  } pgs_state_e;

  typedef struct packed {
    logic rail;
    logic ref_clk;
    logic pwr_clk;
    logic rst;
    logic clamp;
    logic flush_req;
    logic flush_done;
  } pgs_ctrl_t;

  localparam pgs_ctrl_t CTRL_RESET = '{
    rail:       1'b0,
    ref_clk:    1'b0,
    pwr_clk:    1'b0,
    rst:        1'b1,
    clamp:      1'b1,
    flush_req:  1'b1,
    flush_done: 1'b0
  };

endpackage

// File: rtl/pgs_timer.sv
module pgs_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgs_ctrl_reg.sv
module pgs_ctrl_reg #(
  parameter pgs_pkg::pgs_ctrl_t INIT = pgs_pkg::CTRL_RESET
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  pgs_pkg::pgs_ctrl_t d,
  output pgs_pkg::pgs_ctrl_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= INIT;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pgs_pkg::*;
#(
  parameter int TW         = 12,
  parameter int SETTLE_CYC = 2500,
  parameter int RAIL_TMO   = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic          down_req,
  input  logic          err_clear,
  input  logic          secure_cfg_ok,
  input  logic          rail_ready,
  input  logic          flush_ack,
  input  logic          expired,
  input  pgs_ctrl_t     ctrl_q,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          ctrl_we,
  output pgs_ctrl_t     ctrl_d,
  output pgs_state_e    state,
  output logic          error,
  output logic          done
);

  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] RAIL_LD   = TW'(RAIL_TMO - 1);

  pgs_state_e st_n;
  logic       err_set;
  logic       done_n;

  always_comb begin
    st_n     = state;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    ctrl_we  = 1'b0;
    ctrl_d   = ctrl_q;
    err_set  = 1'b0;
    done_n   = 1'b0;
    unique case (state)
      ST_OFF: begin
        if (down_req) begin
          done_n = 1'b1;
        end else if (up_req && !error) begin
          if (!secure_cfg_ok) begin
            err_set = 1'b1;
          end else begin
            st_n        = ST_RAIL;
            ctrl_we     = 1'b1;
            ctrl_d.rail = 1'b1;
            tmr_load    = 1'b1;
            tmr_val     = RAIL_LD;
          end
        end
      end
      ST_ON: begin
        if (down_req) begin
          st_n             = ST_FACK;
          ctrl_we          = 1'b1;
          ctrl_d.flush_req = 1'b1;
        end else if (up_req && !error) begin
          done_n = 1'b1;
        end
      end
      ST_RAIL: begin
        if (rail_ready) begin
          st_n           = ST_CLK;
          ctrl_we        = 1'b1;
          ctrl_d.ref_clk = 1'b1;
          ctrl_d.pwr_clk = 1'b1;
          tmr_load       = 1'b1;
        end else if (expired) begin
          st_n        = ST_OFF;
          ctrl_we     = 1'b1;
          ctrl_d.rail = 1'b0;
          err_set     = 1'b1;
        end
      end
      ST_CLK: begin
        if (expired) begin
          st_n       = ST_RST;
          ctrl_we    = 1'b1;
          ctrl_d.rst = 1'b1;
          tmr_load   = 1'b1;
        end
      end
      ST_RST: begin
        if (expired) begin
          st_n         = ST_CLAMP;
          ctrl_we      = 1'b1;
          ctrl_d.clamp = 1'b0;
          tmr_load     = 1'b1;
        end
      end
      ST_CLAMP: begin
        if (expired) begin
          st_n       = ST_UNRST;
          ctrl_we    = 1'b1;
          ctrl_d.rst = 1'b0;
          tmr_load   = 1'b1;
        end
      end
      ST_UNRST: begin
        if (expired) begin
          st_n              = ST_FDONE;
          ctrl_we           = 1'b1;
          ctrl_d.flush_req  = 1'b0;
          ctrl_d.flush_done = 1'b1;
          tmr_load          = 1'b1;
        end
      end
      ST_FDONE: begin
        if (expired) begin
          st_n              = ST_ON;
          ctrl_we           = 1'b1;
          ctrl_d.flush_done = 1'b0;
          done_n            = 1'b1;
        end
      end
      ST_FACK: begin
        if (flush_ack) begin
          st_n     = ST_FLUSH;
          tmr_load = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (expired) begin
          st_n         = ST_ISO;
          ctrl_we      = 1'b1;
          ctrl_d.clamp = 1'b1;
          tmr_load     = 1'b1;
        end
      end
      ST_ISO: begin
        if (expired) begin
          st_n       = ST_RSTON;
          ctrl_we    = 1'b1;
          ctrl_d.rst = 1'b1;
          tmr_load   = 1'b1;
        end
      end
      ST_RSTON: begin
        if (expired) begin
          st_n           = ST_CLKOFF;
          ctrl_we        = 1'b1;
          ctrl_d.ref_clk = 1'b0;
          ctrl_d.pwr_clk = 1'b0;
          tmr_load       = 1'b1;
        end
      end
      ST_CLKOFF: begin
        if (expired) begin
          st_n        = ST_OFF;
          ctrl_we     = 1'b1;
          ctrl_d.rail = 1'b0;
          done_n      = 1'b1;
        end
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_OFF;
      error <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= st_n;
      done  <= done_n;
      if (err_set) begin
        error <= 1'b1;
      end else if (err_clear) begin
        error <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_US = 10,
  parameter int RAIL_TMO  = 1000,
  parameter int CLIENT_ID = 34,
  parameter int CID_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req,
  input  logic             down_req,
  input  logic             err_clear,
  input  logic             secure_cfg_ok,
  input  logic             rail_ready,
  input  logic             flush_ack,
  output logic             rail_en,
  output logic             ref_clk_en,
  output logic             pwr_clk_en,
  output logic             dom_reset,
  output logic             iso_clamp,
  output logic             mc_flush_req,
  output logic             mc_flush_done,
  output logic [CID_W-1:0] mc_client_id,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             dom_on
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int SPAN       = (SETTLE_CYC > RAIL_TMO) ? SETTLE_CYC : RAIL_TMO;
  localparam int TW         = $clog2(SPAN + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          ctrl_we;
  pgs_ctrl_t     ctrl_d;
  pgs_ctrl_t     ctrl_q;
  pgs_state_e    state;

  pgs_timer #(.TW(TW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pgs_ctrl_reg #(.INIT(CTRL_RESET)) i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .d     (ctrl_d),
    .q     (ctrl_q)
  );

  pgs_fsm #(
    .TW         (TW),
    .SETTLE_CYC (SETTLE_CYC),
    .RAIL_TMO   (RAIL_TMO)
  ) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .up_req        (up_req),
    .down_req      (down_req),
    .err_clear     (err_clear),
    .secure_cfg_ok (secure_cfg_ok),
    .rail_ready    (rail_ready),
    .flush_ack     (flush_ack),
    .expired       (tmr_expired),
    .ctrl_q        (ctrl_q),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .ctrl_we       (ctrl_we),
    .ctrl_d        (ctrl_d),
    .state         (state),
    .error         (error),
    .done          (done)
  );

  assign rail_en       = ctrl_q.rail;
  assign ref_clk_en    = ctrl_q.ref_clk;
  assign pwr_clk_en    = ctrl_q.pwr_clk;
  assign dom_reset     = ctrl_q.rst;
  assign iso_clamp     = ctrl_q.clamp;
  assign mc_flush_req  = ctrl_q.flush_req;
  assign mc_flush_done = ctrl_q.flush_done;
  assign mc_client_id  = CID_W'(CLIENT_ID);
  assign dom_on        = (state == ST_ON);
  assign busy          = (state != ST_ON) && (state != ST_OFF);

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk (
  input logic clk,
  input logic rst_n,
  input logic err_clear,
  input logic rail_en,
  input logic ref_clk_en,
  input logic pwr_clk_en,
  input logic dom_reset,
  input logic iso_clamp,
  input logic mc_flush_req,
  input logic mc_flush_done,
  input logic busy,
  input logic done,
  input logic error
);

  AST_CLK_NEEDS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clk_en || pwr_clk_en) |-> rail_en); // R11

  AST_UNCLAMP_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_clamp |-> (ref_clk_en && pwr_clk_en && rail_en)); // R11

  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mc_flush_req && mc_flush_done)); // R11

  AST_UNCLAMP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_clamp) |-> dom_reset); // R2

  AST_RELEASE_UNCLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_reset) |-> !iso_clamp); // R2

  AST_CLAMP_BEFORE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_reset) |-> iso_clamp); // R3

  AST_ERR_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (!ref_clk_en && !pwr_clk_en)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !err_clear) |=> error); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12

endmodule

bind pwr_gate_seq pgs_chk i_pgs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .err_clear     (err_clear),
  .rail_en       (rail_en),
  .ref_clk_en    (ref_clk_en),
  .pwr_clk_en    (pwr_clk_en),
  .dom_reset     (dom_reset),
  .iso_clamp     (iso_clamp),
  .mc_flush_req  (mc_flush_req),
  .mc_flush_done (mc_flush_done),
  .busy          (busy),
  .done          (done),
  .error         (error)
);

// File: tb/test_pwr_gate_seq.sv
module test_pwr_gate_seq;

  localparam int CLK_MHZ   = 5;
  localparam int SETTLE_US = 10;
  localparam int S         = CLK_MHZ * SETTLE_US;
  localparam int TMO       = 64;

  typedef struct {
    logic [6:0] vec;
    int         gap;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, down_req = 1'b0, err_clear = 1'b0;
  logic secure_cfg_ok = 1'b1, rail_ready = 1'b1, flush_ack = 1'b1;
  logic rail_en, ref_clk_en, pwr_clk_en, dom_reset, iso_clamp;
  logic mc_flush_req, mc_flush_done, busy, done, error, dom_on;
  logic [5:0] mc_client_id;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_chg = 0;
  int done_cnt = 0;
  logic done_prev = 1'b0;
  logic [6:0] prev_vec;
  exp_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_gate_seq #(
    .CLK_MHZ   (CLK_MHZ),
    .SETTLE_US (SETTLE_US),
    .RAIL_TMO  (TMO)
  ) i_pwr_gate_seq (
    .clk (clk), .rst_n (rst_n), .up_req (up_req), .down_req (down_req),
    .err_clear (err_clear), .secure_cfg_ok (secure_cfg_ok),
    .rail_ready (rail_ready), .flush_ack (flush_ack),
    .rail_en (rail_en), .ref_clk_en (ref_clk_en), .pwr_clk_en (pwr_clk_en),
    .dom_reset (dom_reset), .iso_clamp (iso_clamp),
    .mc_flush_req (mc_flush_req), .mc_flush_done (mc_flush_done),
    .mc_client_id (mc_client_id), .busy (busy), .done (done),
    .error (error), .dom_on (dom_on)
  );

  function automatic logic [6:0] cur_vec();
    return {rail_en, ref_clk_en, pwr_clk_en, dom_reset, iso_clamp,
            mc_flush_req, mc_flush_done};
  endfunction

  function automatic logic [6:0] mk(input logic r, input logic c, input logic rs,
                                    input logic cl, input logic fr, input logic fd);
    return {r, c, c, rs, cl, fr, fd};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [6:0] v, input int gap, input string req);
    exp_t e;
    e.vec = v; e.gap = gap; e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: pops one expected vector for each observed change of the controls
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_vec  = cur_vec();
      done_prev = 1'b0;
    end else begin
      if (cur_vec() != prev_vec) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected control change", int'(cur_vec()), int'(prev_vec));
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cur_vec() == e.vec, e.req, int'(cur_vec()), int'(e.vec));
          if (e.gap != 0)
            check(cyc - last_chg == e.gap, {e.req, " R4 spacing"}, cyc - last_chg, e.gap);
        end
        last_chg = cyc;
        prev_vec = cur_vec();
      end
      if (done) done_cnt++;
      if (done && done_prev) check(1'b0, "R12 done wider than one cycle", 2, 1);
      done_prev = done;
    end
  end

  task automatic pulse_up();
    @(negedge clk) up_req = 1'b1;
    @(negedge clk) up_req = 1'b0;
  endtask

  task automatic pulse_down();
    @(negedge clk) down_req = 1'b1;
    @(negedge clk) down_req = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk) err_clear = 1'b1;
    @(negedge clk) err_clear = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sb_drained(input string req);
    check(sb_q.size() == 0, {req, " scoreboard drained"}, sb_q.size(), 0);
  endtask

  task automatic push_up_seq(input string req);
    push(mk(1,0,1,1,1,0), 0,   req);
    push(mk(1,1,1,1,1,0), 0,   req);
    push(mk(1,1,1,0,1,0), 2*S, req);
    push(mk(1,1,0,0,1,0), S,   req);
    push(mk(1,1,0,0,0,1), S,   req);
    push(mk(1,1,0,0,0,0), S,   req);
  endtask

  task automatic push_down_seq(input string req);
    push(mk(1,1,0,0,1,0), 0, req);
    push(mk(1,1,0,1,1,0), 0, req);
    push(mk(1,1,1,1,1,0), S, req);
    push(mk(1,0,1,1,1,0), S, req);
    push(mk(0,0,1,1,1,0), S, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 150000);
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state
    check(cur_vec() == mk(0,0,1,1,1,0), "R1 reset controls", int'(cur_vec()), int'(mk(0,0,1,1,1,0)));
    check(!busy && !error && !dom_on && !done, "R1 reset status", int'({busy,error,dom_on,done}), 0);
    check(mc_client_id == 6'd34, "R10 client id", int'(mc_client_id), 34);

    // R2 / R4 / R7 / R12: full power-up, with an ignored request mid-sequence
    d0 = done_cnt;
    push_up_seq("R2 power-up step");
    pulse_up();
    check(busy == 1'b1, "R12 busy after request", int'(busy), 1);
    repeat (30) @(negedge clk);
    pulse_down();   // R7: arrives while busy
    pulse_up();     // R7: arrives while busy
    wait_idle();
    check(dom_on == 1'b1, "R2 domain on", int'(dom_on), 1);
    check(done_cnt == d0 + 1, "R12 one done per power-up", done_cnt, d0 + 1);
    sb_drained("R2");

    // R8: power-up while on
    d0 = done_cnt;
    pulse_up();
    @(negedge clk);
    check(done_cnt == d0 + 1 && !busy, "R8 up while on completes", done_cnt, d0 + 1);
    sb_drained("R8 up while on");

    // R3: power-down, flush acknowledge held back
    flush_ack = 1'b0;
    d0 = done_cnt;
    push_down_seq("R3 power-down step");
    pulse_down();
    repeat (3 * S) @(negedge clk);
    check(iso_clamp == 1'b0 && busy, "R3 waits for flush ack", int'(iso_clamp), 0);
    flush_ack = 1'b1;
    wait_idle();
    check(!dom_on && !busy, "R3 domain off", int'(dom_on), 0);
    check(done_cnt == d0 + 1, "R12 one done per power-down", done_cnt, d0 + 1);
    sb_drained("R3");

    // R8: power-down while off
    d0 = done_cnt;
    pulse_down();
    @(negedge clk);
    check(done_cnt == d0 + 1, "R8 down while off completes", done_cnt, d0 + 1);

    // R5: bad security configuration aborts power-up
    secure_cfg_ok = 1'b0;
    d0 = done_cnt;
    pulse_up();
    repeat (3) @(negedge clk);
    check(error == 1'b1, "R5 error on bad security config", int'(error), 1);
    check(done_cnt == d0 && !busy, "R5 no done, no sequence", done_cnt, d0);
    sb_drained("R5 no control change");

    // R9: error is sticky, up ignored, down accepted, clear works
    secure_cfg_ok = 1'b1;
    pulse_up();
    repeat (3) @(negedge clk);
    check(error && !busy && !dom_on && done_cnt == d0, "R9 up ignored in error", done_cnt, d0);
    pulse_down();
    @(negedge clk);
    check(done_cnt == d0 + 1 && error, "R9 down accepted in error", done_cnt, d0 + 1);
    pulse_clear();
    check(error == 1'b0, "R9 clear drops error", int'(error), 0);

    // R6: rail never ready
    rail_ready = 1'b0;
    d0 = done_cnt;
    push(mk(1,0,1,1,1,0), 0,   "R6 rail on");
    push(mk(0,0,1,1,1,0), TMO, "R6 rail dropped at timeout");
    pulse_up();
    wait_idle();
    check(error && !dom_on && done_cnt == d0, "R6 timeout error", int'(error), 1);
    sb_drained("R6");
    pulse_clear();

    // R2: rail ready arrives late, then a clean power-down
    push_up_seq("R2 late rail step");
    pulse_up();
    repeat (10) @(negedge clk);
    rail_ready = 1'b1;
    wait_idle();
    check(dom_on && !error, "R2 on after late rail ready", int'(dom_on), 1);
    sb_drained("R2 late rail");
    push_down_seq("R3 second power-down step");
    pulse_down();
    wait_idle();
    check(!dom_on, "R3 off again", int'(dom_on), 0);
    sb_drained("R3 second");

    summary();
    $finish;
  end

endmodule